// File: doc/BRIEF.md
# SPI Flash Window Access Sequencer

This block converts a single processor load or store that falls inside one chip-select's flash window into the byte sequence a serial flash device expects. Each chip select owns a 32-bit control word. The word holds an access mode, a command opcode, a dummy-length code and a stop bit that drives the chip-select line. Two further per-chip-select bits, each held in its own small register, allow stores and select 4-byte addressing. The sequencer passes one byte at a time to an external shift engine through a valid/done handshake, and it drives one active-low select line per chip select.

Three of the modes are framed: normal read, fast read and write. A framed access drops the select line, sends an opcode, then the address, then any filler bytes, then 1 to 4 data bytes, and finally raises the line again. User mode passes only data bytes and leaves the select line to software. Accesses whose direction does not fit the mode, and stores that are not allowed, are answered without any transfer. The bus side accepts one request at a time with valid/ready and answers with a one-cycle response strobe.

Top module: `spi_window_sequencer`

## Requirements
- R1: After reset every `cs_n` line is high, `req_ready` is high, and neither `xfer_valid` nor `resp_valid` is asserted. Each control word resets to 0x0000_0004, the write-allow bits reset to 0 and the address-width bits reset to 0.
- R2: Control word bits [1:0] select the mode: 0 is normal read, 1 is fast read, 2 is write and 3 is user mode.
- R3: A framed access sends control bits [23:16] as its opcode. The exception is normal-read mode, which always sends 0x03.
- R4: For a framed access, `cs_n` of the target goes low in the cycle after acceptance and stays low for every transfer. The transfers are, in order: the opcode, then the address most-significant byte first, then the data bytes. `cs_n` returns high in the cycle after `resp_valid`.
- R5: The address phase sends 4 bytes (bits [31:0]) when bit `ce` of the address-width register is set. Otherwise it sends 3 bytes (bits [23:0]).
- R6: In fast-read mode only, ({bit14, bits[7:6]}) × 8 bytes of 0xFF are sent between the address and the data.
- R7: In user mode there is no opcode, no address and no select change. A read sends 0x00 once per byte. A write sends its data bytes.
- R8: Data is little-endian: byte i occupies bits [8i+7:8i]. The byte count is `req_bytes_m1`+1 (1 to 4), and data bytes go out in order i = 0, 1, 2 and so on.
- R9: A write whose write-allow bit (bit 16+`ce` of the write-allow register) is clear makes no transfer and leaves `cs_n` unchanged. It still gets a response.
- R10: A read in write mode, or a write in read or fast-read mode, makes no transfer. Its response carries `resp_rdata` = 0.
- R11: `cs_n[ce]` equals bit 2 of that control word, so a configuration write to the word changes the line in the next cycle.
- R12: `req_ready` is low from acceptance until the response. `resp_valid` lasts one cycle. `resp_err` is set with it when a framed access resolves to opcode 0x00. Write responses return `resp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control word, 1 write-allow register, 2 address-width register |
| cfg_ce | input | CE_W | Chip select whose control word is written |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 store, 0 load |
| req_ce | input | CE_W | Target chip select |
| req_addr | input | 32 | Byte address inside the window |
| req_bytes_m1 | input | SZ_W | Access size minus one |
| req_wdata | input | DATA_W | Store data, little-endian |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_rdata | output | DATA_W | Load data, little-endian |
| resp_err | output | 1 | Framed access with zero opcode |
| xfer_valid | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Shift engine finished the byte |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_done |
| cs_n | output | NUM_CE | Active-low chip selects |

## Verification
A configuration write shows on `cs_n` at the first sample after its clock edge. An accepted framed access shows `cs_n` low and `xfer_valid` high one edge after acceptance. After that, each byte takes exactly the edge on which `xfer_done` is seen. `resp_valid` follows one edge after the last data byte, or one edge after acceptance when the access is dropped, and `cs_n` rises one edge after that. The bench's shift-engine model logs every byte and the select level at the moment it raises `xfer_done`. Every output is sampled on the falling clock edge, so the response is read in the cycle it is due and the released select is read one cycle later. The sweep covers both chip selects, all four modes, both directions, write-allow on and off, both address widths, every size and all eight dummy codes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_DROP   = 2'd0,
    ACT_RAW    = 2'd1,
    ACT_FRAMED = 2'd2
  } act_e;

  typedef struct packed {
    act_e        act;
    logic [7:0]  opcode;
    logic [1:0]  addr_last;   // index of first (most significant) address byte
    logic [5:0]  dummies;
    logic        op_err;
  } plan_t;

  localparam int         STOP_BIT    = 2;
  localparam int         OPC_LSB     = 16;
  localparam int         WEN_LSB     = 16;
  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_WEN  = 2'd1;
  localparam logic [1:0] SEL_AW   = 2'd2;

  function automatic logic [5:0] dummy_count(input logic [31:0] w);
    return {w[14], w[7:6], 3'b000};
  endfunction

endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
  import fseq_pkg::*;
#(
  parameter int NUM_CE = 2,
  parameter int CE_W   = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [CE_W-1:0]         cfg_ce,
  input  logic [31:0]             cfg_wdata,
  input  logic [NUM_CE-1:0]       seq_select,
  input  logic [NUM_CE-1:0]       seq_release,
  output logic [NUM_CE-1:0][31:0] ctrl_o,
  output logic [NUM_CE-1:0]       wen_o,
  output logic [NUM_CE-1:0]       aw_o,
  output logic [NUM_CE-1:0]       cs_n_o
);

  localparam logic [31:0] CTRL_RST = 32'(1) << STOP_BIT;

  logic [NUM_CE-1:0] wen_q;
  logic [NUM_CE-1:0] aw_q;

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    logic [31:0] word_q;
    logic        hit;

    assign hit = cfg_we && (cfg_sel == SEL_CTRL) && (cfg_ce == CE_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= CTRL_RST;
      end else begin
        if (hit) word_q <= cfg_wdata;
        if (seq_select[g])  word_q[STOP_BIT] <= 1'b0;
        if (seq_release[g]) word_q[STOP_BIT] <= 1'b1;
      end
    end

    assign ctrl_o[g] = word_q;
    assign cs_n_o[g] = word_q[STOP_BIT];

    // R4
    release_high_chk: assert property (@(posedge clk) disable iff (rst)
      seq_release[g] |=> cs_n_o[g]);

    // R11
    cfg_cs_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && !seq_select[g] && !seq_release[g]) |=> (cs_n_o[g] == $past(cfg_wdata[STOP_BIT])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q <= '0;
      aw_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_WEN) wen_q <= cfg_wdata[WEN_LSB +: NUM_CE];
      if (cfg_sel == SEL_AW)  aw_q  <= cfg_wdata[NUM_CE-1:0];
    end
  end

  assign wen_o = wen_q;
  assign aw_o  = aw_q;

endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
(
  input  logic [31:0] ctrl,
  input  logic        wen,
  input  logic        aw,
  input  logic        is_write,
  output plan_t       plan
);

  mode_e mode;
  logic  unused_ctrl;

  assign mode        = mode_e'(ctrl[1:0]);
  assign unused_ctrl = ^{ctrl[31:24], ctrl[13:8], ctrl[5:2]};

  always_comb begin
    plan           = '0;
    plan.act       = ACT_FRAMED;
    plan.opcode    = (mode == MODE_READ) ? READ_OPCODE : ctrl[OPC_LSB +: 8];
    plan.addr_last = aw ? 2'd3 : 2'd2;
    plan.dummies   = (mode == MODE_FAST) ? dummy_count(ctrl) : 6'd0;
    if (is_write && !wen) begin
      plan.act = ACT_DROP;
    end else if (mode == MODE_USER) begin
      plan.act = ACT_RAW;
    end else if (is_write != (mode == MODE_WRITE)) begin
      plan.act = ACT_DROP;
    end
    plan.op_err = (plan.act == ACT_FRAMED) && (plan.opcode == 8'h00);
  end

endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
  import fseq_pkg::*;
#(
  parameter int NUM_CE    = 2,
  parameter int CE_W      = 1,
  parameter int MAX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [CE_W-1:0]        req_ce,
  input  logic [31:0]            req_addr,
  input  logic [$clog2(MAX_BYTES)-1:0] req_bytes_m1,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  input  plan_t                  plan,
  output logic                   resp_valid,
  output logic [8*MAX_BYTES-1:0] resp_rdata,
  output logic                   resp_err,
  output logic                   xfer_valid,
  output logic [7:0]             xfer_tx,
  input  logic                   xfer_done,
  input  logic [7:0]             xfer_rx,
  output logic [NUM_CE-1:0]      seq_select,
  output logic [NUM_CE-1:0]      seq_release,
  output logic [CE_W-1:0]        active_ce,
  output logic                   framed_o
);

  localparam int SZ_W   = $clog2(MAX_BYTES);
  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int CNT_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_FIN
  } state_e;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        op_q;
  logic [31:0]       addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [SZ_W-1:0]   size_q;
  logic [5:0]        dummies_q;
  logic [CE_W-1:0]   ce_q;
  logic              wr_q;
  logic              framed_q;
  logic              err_q;
  logic              accept;
  logic              step;

  assign accept = req_valid && (state == ST_IDLE);
  assign step   = xfer_valid && xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      size_q    <= '0;
      dummies_q <= '0;
      ce_q      <= '0;
      wr_q      <= 1'b0;
      framed_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q      <= plan.opcode;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          rdata_q   <= '0;
          size_q    <= req_bytes_m1;
          dummies_q <= plan.dummies;
          ce_q      <= req_ce;
          wr_q      <= req_write;
          framed_q  <= (plan.act == ACT_FRAMED);
          err_q     <= plan.op_err;
          cnt       <= '0;
          unique case (plan.act)
            ACT_DROP:   state <= ST_FIN;
            ACT_RAW:    state <= ST_DATA;
            default:    state <= ST_CMD;
          endcase
        end
        ST_CMD: if (step) begin
          state <= ST_ADDR;
          cnt   <= CNT_W'(plan_addr_last_q);
        end
        ST_ADDR: if (step) begin
          if (cnt == '0) begin
            if (dummies_q != '0) begin
              state <= ST_DUMMY;
              cnt   <= CNT_W'(dummies_q - 6'd1);
            end else begin
              state <= ST_DATA;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DUMMY: if (step) begin
          if (cnt == '0) state <= ST_DATA;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DATA: if (step) begin
          if (!wr_q) rdata_q[{cnt[SZ_W-1:0], 3'b000} +: 8] <= xfer_rx;
          if (cnt[SZ_W-1:0] == size_q) begin
            state <= ST_FIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Address width is latched with the rest of the plan.
  logic [1:0] plan_addr_last_q;
  always_ff @(posedge clk) begin
    if (rst)         plan_addr_last_q <= 2'd2;
    else if (accept) plan_addr_last_q <= plan.addr_last;
  end

  always_comb begin
    unique case (state)
      ST_CMD:   xfer_tx = op_q;
      ST_ADDR:  xfer_tx = addr_q[{cnt[1:0], 3'b000} +: 8];
      ST_DUMMY: xfer_tx = FILL_BYTE;
      ST_DATA:  xfer_tx = wr_q ? wdata_q[{cnt[SZ_W-1:0], 3'b000} +: 8] : 8'h00;
      default:  xfer_tx = 8'h00;
    endcase
  end

  assign xfer_valid  = (state == ST_CMD) || (state == ST_ADDR) ||
                       (state == ST_DUMMY) || (state == ST_DATA);
  assign req_ready   = (state == ST_IDLE);
  assign resp_valid  = (state == ST_FIN);
  assign resp_rdata  = rdata_q;
  assign resp_err    = err_q && (state == ST_FIN);
  assign seq_select  = (accept && plan.act == ACT_FRAMED) ? (NUM_CE'(1) << req_ce) : '0;
  assign seq_release = ((state == ST_FIN) && framed_q) ? (NUM_CE'(1) << ce_q) : '0;
  assign active_ce   = ce_q;
  assign framed_o    = framed_q;

  // R12
  accept_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R12
  resp_single_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (req_ready && !resp_valid));

  // R10
  write_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && wr_q) |-> (resp_rdata == '0));

endmodule

// File: rtl/spi_window_sequencer.sv
module spi_window_sequencer
  import fseq_pkg::*;
#(
  parameter int NUM_CE    = 2,
  parameter int MAX_BYTES = 4,
  localparam int CE_W     = (NUM_CE > 1) ? $clog2(NUM_CE) : 1,
  localparam int SZ_W     = $clog2(MAX_BYTES),
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CE_W-1:0]   cfg_ce,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CE_W-1:0]   req_ce,
  input  logic [31:0]       req_addr,
  input  logic [SZ_W-1:0]   req_bytes_m1,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic [NUM_CE-1:0] cs_n
);

  logic [NUM_CE-1:0][31:0] ctrl_words;
  logic [NUM_CE-1:0]       wen_bits;
  logic [NUM_CE-1:0]       aw_bits;
  logic [NUM_CE-1:0]       seq_select;
  logic [NUM_CE-1:0]       seq_release;
  logic [CE_W-1:0]         eng_ce;
  logic                    eng_framed;
  plan_t                   plan;

  fseq_regs #(.NUM_CE(NUM_CE), .CE_W(CE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_ce      (cfg_ce),
    .cfg_wdata   (cfg_wdata),
    .seq_select  (seq_select),
    .seq_release (seq_release),
    .ctrl_o      (ctrl_words),
    .wen_o       (wen_bits),
    .aw_o        (aw_bits),
    .cs_n_o      (cs_n)
  );

  fseq_decode u_decode (
    .ctrl     (ctrl_words[req_ce]),
    .wen      (wen_bits[req_ce]),
    .aw       (aw_bits[req_ce]),
    .is_write (req_write),
    .plan     (plan)
  );

  fseq_engine #(.NUM_CE(NUM_CE), .CE_W(CE_W), .MAX_BYTES(MAX_BYTES)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_ce       (req_ce),
    .req_addr     (req_addr),
    .req_bytes_m1 (req_bytes_m1),
    .req_wdata    (req_wdata),
    .plan         (plan),
    .resp_valid   (resp_valid),
    .resp_rdata   (resp_rdata),
    .resp_err     (resp_err),
    .xfer_valid   (xfer_valid),
    .xfer_tx      (xfer_tx),
    .xfer_done    (xfer_done),
    .xfer_rx      (xfer_rx),
    .seq_select   (seq_select),
    .seq_release  (seq_release),
    .active_ce    (eng_ce),
    .framed_o     (eng_framed)
  );

  // R4
  framed_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && eng_framed) |-> !cs_n[eng_ce]);

endmodule

// File: tb/spi_window_sequencer_test.sv
module spi_window_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [0:0]  cfg_ce = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [0:0]  req_ce = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_bytes_m1 = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        resp_err;
  logic        xfer_valid;
  logic [7:0]  xfer_tx;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = '0;
  logic [1:0]  cs_n;

  always #5 clk = ~clk;

  spi_window_sequencer #(.NUM_CE(2), .MAX_BYTES(4)) uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ce(cfg_ce), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_ce(req_ce), .req_addr(req_addr), .req_bytes_m1(req_bytes_m1),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_err(resp_err), .xfer_valid(xfer_valid), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n)
  );

  int checks = 0;
  int failures = 0;

  logic [7:0] log_tx [0:127];
  logic [7:0] log_rx [0:127];
  logic       log_cs [0:127];
  int         log_n = 0;
  int         cur_ce = 0;
  logic [7:0] rx_seed = 8'h31;

  // Shift-engine model: completes each requested byte one cycle after it appears.
  always @(negedge clk) begin
    if (rst) begin
      xfer_done = 1'b0;
    end else if (xfer_valid && !xfer_done) begin
      xfer_rx = rx_seed;
      if (log_n < 128) begin
        log_tx[log_n] = xfer_tx;
        log_rx[log_n] = rx_seed;
        log_cs[log_n] = cs_n[cur_ce];
      end
      log_n   = log_n + 1;
      rx_seed = rx_seed + 8'd7;
      xfer_done = 1'b1;
    end else begin
      xfer_done = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int ce, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_ce = 1'(ce); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input int ce, input bit wr, input logic [31:0] addr, input int nb,
                        input logic [31:0] wd, output logic [31:0] rd, output bit er);
    @(negedge clk);
    log_n = 0; cur_ce = ce;
    req_valid = 1'b1; req_write = wr; req_ce = 1'(ce); req_addr = addr;
    req_bytes_m1 = 2'(nb - 1); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata;
    er = resp_err;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  exp_tx [0:127];
    int          exp_n, hdr, mism;
    bit          ignored, framed, seq_ok, cs_ok, er, exp_er;
    logic [7:0]  op, opres;
    logic [2:0]  dsel;
    logic [31:0] ctrl, addr, wd, rd, exp_rd;
    string       tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cs_n == 2'b11, "R1 cs_n", {30'd0, cs_n}, 32'h3);
    chk(req_ready && !xfer_valid && !resp_valid, "R1 idle",
        {29'd0, req_ready, xfer_valid, resp_valid}, 32'h4);

    // R11 stop bit drives the select line directly
    cfg_write(2'd0, 0, 32'h0000_0000);
    chk(cs_n == 2'b10, "R11 low", {30'd0, cs_n}, 32'h2);
    cfg_write(2'd0, 0, 32'h0000_0004);
    chk(cs_n == 2'b11, "R11 high", {30'd0, cs_n}, 32'h3);

    for (int ce = 0; ce < 2; ce++)
    for (int mode = 0; mode < 4; mode++)
    for (int wr = 0; wr < 2; wr++)
    for (int we = 0; we < 2; we++)
    for (int aw = 0; aw < 2; aw++)
    for (int nb = 1; nb <= 4; nb++) begin
      dsel = 3'((nb + aw * 4) % 8);
      op   = (nb == 2) ? 8'h00 : 8'(8'h0B + nb * 16 + ce);
      ctrl = (32'(op) << 16) | (32'(dsel[2]) << 14) | (32'(dsel[1:0]) << 6) | 32'h4 | 32'(mode);
      addr = 32'h9A00_0000 + 32'(nb) * 32'h0101_0101 + 32'(mode) * 32'h0010_2030 + 32'(ce);
      wd   = 32'hC3D2_E1F0 ^ (32'(nb) << 8) ^ (32'(mode) << 20) ^ 32'(ce);
      cfg_write(2'd1, 0, we ? (32'h1 << (16 + ce)) : 32'h0);
      cfg_write(2'd2, 0, aw ? (32'h1 << ce) : 32'h0);
      cfg_write(2'd0, ce, ctrl);

      ignored = (wr && !we) || (wr && mode < 2) || (!wr && mode == 2);
      framed  = !ignored && (mode != 3);
      opres   = (mode == 0) ? 8'h03 : op;
      exp_n = 0; hdr = 0;
      if (!ignored) begin
        if (framed) begin
          exp_tx[exp_n] = opres; exp_n++;
          for (int b = (aw ? 3 : 2); b >= 0; b--) begin
            exp_tx[exp_n] = addr[b*8 +: 8]; exp_n++;
          end
          if (mode == 1)
            for (int d = 0; d < int'(dsel) * 8; d++) begin
              exp_tx[exp_n] = 8'hFF; exp_n++;
            end
        end
        hdr = exp_n;
        for (int i = 0; i < nb; i++) begin
          exp_tx[exp_n] = wr ? wd[i*8 +: 8] : 8'h00; exp_n++;
        end
      end

      access(ce, wr[0], addr, nb, wd, rd, er);

      if (ignored) tag = (wr && !we) ? "R9" : "R10";
      else if (mode == 3) tag = "R7 R8";
      else if (mode == 1) tag = "R2 R3 R4 R5 R6 R8";
      else tag = "R2 R3 R4 R5 R8";

      seq_ok = (log_n == exp_n);
      mism = 0;
      for (int i = 0; i < exp_n; i++)
        if (seq_ok && log_tx[i] !== exp_tx[i]) begin
          seq_ok = 1'b0; mism = i;
        end
      chk(seq_ok, tag,
          (log_n == exp_n) ? {24'd0, log_tx[mism]} : 32'(log_n),
          (log_n == exp_n) ? {24'd0, exp_tx[mism]} : 32'(exp_n));

      exp_rd = '0;
      if (!ignored && !wr)
        for (int i = 0; i < nb; i++)
          exp_rd[i*8 +: 8] = (hdr + i < 128) ? log_rx[hdr + i] : 8'h00;
      chk(rd === exp_rd, ignored ? "R10 rdata" : "R8 rdata", rd, exp_rd);

      exp_er = framed && (opres == 8'h00);
      chk(er == exp_er, "R12 err", {31'd0, er}, {31'd0, exp_er});

      if (log_n > 0) begin
        cs_ok = 1'b1;
        for (int i = 0; i < log_n && i < 128; i++)
          if (log_cs[i] !== !framed) cs_ok = 1'b0;
        chk(cs_ok, framed ? "R4 cs during" : "R7 cs during", {31'd0, cs_ok}, 32'h1);
      end

      chk(cs_n == 2'b11 && req_ready, ignored ? "R9 R12 after" : "R4 R12 after",
          {29'd0, req_ready, cs_n}, 32'h7);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule